// File: doc/BRIEF.md
# Waveform RAM player

The block stores up to 1024 samples of 32 bits and plays a stretch of them, one sample per timer period, onto the control inputs of a numerically controlled oscillator. Eight profile slots each describe one stretch of memory (a first and a last address), a timer reload value that paces the stretch, and a destination. A three-bit select input picks the active slot. Each sample is sent to the frequency word, the phase word or the amplitude word. In the polar destination, one sample drives both the phase and the magnitude words at once.

Software loads the memory and the profile slots through simple write ports while playback is off. It then raises the playback enable and starts a stretch in one of two ways: it pulses the update strobe, or it moves the profile select. Each parameter output is registered and carries a one-cycle valid flag. A done flag marks the last sample of the stretch and stays high until the next start.

Top module: `wave_ram_player`

## Requirements
- R1: A memory write through `mem_we`/`mem_addr`/`mem_wdata` takes effect only while `play_en` is low. A write made while `play_en` is high leaves the stored word unchanged.
- R2: Playback starts only when `play_en` is high and either `update` is high or `profile_sel` differs from the value sampled at the previous edge. A strobe while disabled, or raising `play_en` alone, produces no samples.
- R3: The first sample of a stretch appears on the outputs after the second rising edge that follows the edge which samples the start condition. Later samples follow every `rate+1` cycles, so a rate of 0 gives one sample per cycle.
- R4: A profile select change sampled at a rising edge starts playback with the settings of the newly selected slot from that edge on.
- R5: Destination code 00 routes the whole 32-bit sample to `freq_word`. Code 01 routes sample bits [31:16] to `phase_word`. Code 10 routes sample bits [31:18] to `amp_word`. Only the matching valid flag pulses.
- R6: Destination code 11 (polar) drives `phase_word` from sample bits [31:16] and `amp_word` from bits [15:2]. Bits [1:0] are dropped. Both valid flags pulse in the same cycle and `freq_vld` stays low.
- R7: Samples are read from the first address upward to the last address. The address wraps from 1023 to 0.
- R8: `done` rises in the same cycle as the output of the last-address sample. It then stays high, and no further sample is output until the next start.
- R9: A new start during playback clears `done` at the start edge and restarts from the first address of the selected slot. A sample fetched before that edge is discarded.
- R10: While `play_en` is low, no valid flag pulses and `done` is low from the next edge on.
- R11: After synchronous reset, all parameter outputs are zero, all valid flags are low and `done` is low. All profile slots read as first 0, last 0, rate 0 and destination 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; profile select is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| play_en | input | 1 | Playback enable; also locks memory writes while high |
| update | input | 1 | One-cycle strobe that starts the selected stretch |
| profile_sel | input | 3 | Active profile slot; a change starts that slot |
| mem_we | input | 1 | Memory write enable |
| mem_addr | input | 10 | Memory write address |
| mem_wdata | input | 32 | Memory write data |
| prof_we | input | 1 | Profile slot write enable |
| prof_idx | input | 3 | Profile slot written |
| prof_first | input | 10 | First address of the stretch |
| prof_last | input | 10 | Last address of the stretch |
| prof_rate | input | 16 | Timer reload; sample interval is rate+1 cycles |
| prof_dest | input | 2 | Destination: 00 freq, 01 phase, 10 amp, 11 polar |
| freq_word | output | 32 | Frequency word |
| freq_vld | output | 1 | One-cycle pulse when freq_word is updated |
| phase_word | output | 16 | Phase word |
| phase_vld | output | 1 | One-cycle pulse when phase_word is updated |
| amp_word | output | 14 | Amplitude or magnitude word |
| amp_vld | output | 1 | One-cycle pulse when amp_word is updated |
| done | output | 1 | Last sample of the stretch has been output |

## Verification
The scoreboard predicts the exact cycle of every sample for rates of 0 through 4. An off-by-one timer reload therefore shows up as a timing mismatch, and so does a memory read without latency. Stretches that wrap past address 1023, single-sample stretches and the polar split are run so that a wrong increment, a missed end compare or a swapped bit field gives a wrong word or a misplaced `done`. A restart is placed exactly on a fetch edge, so a design that lets the in-flight sample escape emits an unexpected sample. Memory writes are made both while enabled and while disabled, so a missing write lock replays a corrupted word.

// File: rtl/wrp_pkg.sv
package wrp_pkg;

    parameter int unsigned WRP_ADDR_W  = 10;
    parameter int unsigned WRP_DATA_W  = 32;
    parameter int unsigned WRP_PROF_N  = 8;
    parameter int unsigned WRP_RATE_W  = 16;
    parameter int unsigned WRP_PHASE_W = 16;
    parameter int unsigned WRP_MAG_W   = 14;

    localparam int unsigned WRP_SEL_W = $clog2(WRP_PROF_N);
    localparam int unsigned WRP_DEPTH = 1 << WRP_ADDR_W;

    typedef logic [WRP_ADDR_W-1:0]  wrp_addr_t;
    typedef logic [WRP_DATA_W-1:0]  wrp_word_t;
    typedef logic [WRP_RATE_W-1:0]  wrp_rate_t;
    typedef logic [WRP_SEL_W-1:0]   wrp_sel_t;
    typedef logic [WRP_PHASE_W-1:0] wrp_phase_t;
    typedef logic [WRP_MAG_W-1:0]   wrp_mag_t;

    typedef enum logic [1:0] {
        DST_FREQ  = 2'b00,
        DST_PHASE = 2'b01,
        DST_AMP   = 2'b10,
        DST_POLAR = 2'b11
    } wrp_dest_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'b00,
        SQ_RUN  = 2'b01,
        SQ_HOLD = 2'b10
    } wrp_state_e;

    typedef struct packed {
        wrp_addr_t first;
        wrp_addr_t last;
        wrp_rate_t rate;
        wrp_dest_e dest;
    } wrp_prof_t;

    // travels alongside a memory read
    typedef struct packed {
        logic      vld;
        logic      fin;
        wrp_dest_e dest;
    } wrp_tag_t;

    function automatic wrp_addr_t wrp_next(input wrp_addr_t a);
        return a + wrp_addr_t'(1);
    endfunction

    function automatic wrp_phase_t wrp_phase_of(input wrp_word_t w);
        return w[WRP_DATA_W-1 -: WRP_PHASE_W];
    endfunction

    function automatic wrp_mag_t wrp_amp_single(input wrp_word_t w);
        return w[WRP_DATA_W-1 -: WRP_MAG_W];
    endfunction

    function automatic wrp_mag_t wrp_mag_polar(input wrp_word_t w);
        return w[WRP_DATA_W-WRP_PHASE_W-1 -: WRP_MAG_W];
    endfunction

endpackage

// File: rtl/wrp_mem.sv
module wrp_mem #(
    parameter int unsigned ADDR_W = wrp_pkg::WRP_ADDR_W,
    parameter int unsigned DATA_W = wrp_pkg::WRP_DATA_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end
endmodule

// File: rtl/wrp_prof_bank.sv
module wrp_prof_bank
    import wrp_pkg::*;
#(
    parameter int unsigned PROF_N = WRP_PROF_N
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [$clog2(PROF_N)-1:0]   widx,
    input  wrp_prof_t                   wval,
    input  logic [$clog2(PROF_N)-1:0]   ridx,
    output wrp_prof_t                   rval
);
    localparam int unsigned IDX_W = $clog2(PROF_N);

    wrp_prof_t slots [PROF_N];

    for (genvar g = 0; g < PROF_N; g++) begin : g_slot
        wrp_prof_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                r <= wval;
            end
        end
        assign slots[g] = r;
    end

    assign rval = slots[ridx];
endmodule

// File: rtl/wrp_seq.sv
module wrp_seq
    import wrp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      play_en,
    input  logic      update,
    input  wrp_sel_t  prof_sel,
    input  wrp_prof_t sel_cfg,
    output logic      rd_en,
    output wrp_addr_t rd_addr,
    output wrp_tag_t  tag,
    output logic      flush
);
    wrp_sel_t   sel_q;
    wrp_state_e st;
    wrp_addr_t  addr;
    wrp_rate_t  tmr;
    wrp_prof_t  act;

    logic chg, start, fetch, at_end;

    assign chg    = (prof_sel != sel_q);
    assign start  = play_en && (update || chg);
    assign at_end = (addr == act.last);
    assign fetch  = play_en && !start && (st == SQ_RUN) && (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            st    <= SQ_IDLE;
            addr  <= '0;
            tmr   <= '0;
            act   <= '0;
        end else begin
            sel_q <= prof_sel;
            if (!play_en) begin
                st <= SQ_IDLE;
            end else if (start) begin
                act  <= sel_cfg;
                addr <= sel_cfg.first;
                tmr  <= '0;
                st   <= SQ_RUN;
            end else if (st == SQ_RUN) begin
                if (tmr == '0) begin
                    tmr <= act.rate;
                    if (at_end) begin
                        st <= SQ_HOLD;
                    end else begin
                        addr <= wrp_next(addr);
                    end
                end else begin
                    tmr <= tmr - wrp_rate_t'(1);
                end
            end
        end
    end

    assign rd_en    = fetch;
    assign rd_addr  = addr;
    assign tag.vld  = fetch;
    assign tag.fin  = at_end;
    assign tag.dest = act.dest;
    assign flush    = start || !play_en;
endmodule

// File: rtl/wrp_router.sv
module wrp_router
    import wrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  wrp_tag_t   tag_in,
    input  wrp_word_t  rd_data,
    output wrp_word_t  freq_word,
    output logic       freq_vld,
    output wrp_phase_t phase_word,
    output logic       phase_vld,
    output wrp_mag_t   amp_word,
    output logic       amp_vld,
    output logic       done
);
    wrp_tag_t tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q      <= '0;
            freq_word  <= '0;
            phase_word <= '0;
            amp_word   <= '0;
            freq_vld   <= 1'b0;
            phase_vld  <= 1'b0;
            amp_vld    <= 1'b0;
            done       <= 1'b0;
        end else begin
            freq_vld  <= 1'b0;
            phase_vld <= 1'b0;
            amp_vld   <= 1'b0;
            if (flush) begin
                tag_q <= '0;
                done  <= 1'b0;
            end else begin
                tag_q <= tag_in;
                if (tag_q.vld) begin
                    done <= tag_q.fin;
                    case (tag_q.dest)
                        DST_FREQ: begin
                            freq_word <= rd_data;
                            freq_vld  <= 1'b1;
                        end
                        DST_PHASE: begin
                            phase_word <= wrp_phase_of(rd_data);
                            phase_vld  <= 1'b1;
                        end
                        DST_AMP: begin
                            amp_word <= wrp_amp_single(rd_data);
                            amp_vld  <= 1'b1;
                        end
                        DST_POLAR: begin
                            phase_word <= wrp_phase_of(rd_data);
                            amp_word   <= wrp_mag_polar(rd_data);
                            phase_vld  <= 1'b1;
                            amp_vld    <= 1'b1;
                        end
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/wave_ram_player.sv
module wave_ram_player
    import wrp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        play_en,
    input  logic        update,
    input  logic [2:0]  profile_sel,
    input  logic        mem_we,
    input  logic [9:0]  mem_addr,
    input  logic [31:0] mem_wdata,
    input  logic        prof_we,
    input  logic [2:0]  prof_idx,
    input  logic [9:0]  prof_first,
    input  logic [9:0]  prof_last,
    input  logic [15:0] prof_rate,
    input  logic [1:0]  prof_dest,
    output logic [31:0] freq_word,
    output logic        freq_vld,
    output logic [15:0] phase_word,
    output logic        phase_vld,
    output logic [13:0] amp_word,
    output logic        amp_vld,
    output logic        done
);
    wrp_prof_t wr_prof, sel_cfg;
    wrp_tag_t  tag;
    wrp_addr_t rd_addr;
    wrp_word_t rd_data;
    logic      rd_en, flush, mem_wr_ok;

    assign wr_prof.first = prof_first;
    assign wr_prof.last  = prof_last;
    assign wr_prof.rate  = prof_rate;
    assign wr_prof.dest  = wrp_dest_e'(prof_dest);

    // memory is locked while playback is enabled
    assign mem_wr_ok = mem_we && !play_en;

    wrp_prof_bank #(.PROF_N(WRP_PROF_N)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (prof_we),
        .widx (prof_idx),
        .wval (wr_prof),
        .ridx (profile_sel),
        .rval (sel_cfg)
    );

    wrp_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .play_en  (play_en),
        .update   (update),
        .prof_sel (profile_sel),
        .sel_cfg  (sel_cfg),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .tag      (tag),
        .flush    (flush)
    );

    wrp_mem #(.ADDR_W(WRP_ADDR_W), .DATA_W(WRP_DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (mem_wr_ok),
        .wr_addr (mem_addr),
        .wr_data (mem_wdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wrp_router u_route (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .tag_in     (tag),
        .rd_data    (rd_data),
        .freq_word  (freq_word),
        .freq_vld   (freq_vld),
        .phase_word (phase_word),
        .phase_vld  (phase_vld),
        .amp_word   (amp_word),
        .amp_vld    (amp_vld),
        .done       (done)
    );
endmodule

// File: rtl/wrp_chk.sv
module wrp_chk (
    input logic        clk,
    input logic        rst,
    input logic        play_en,
    input logic [31:0] freq_word,
    input logic        freq_vld,
    input logic [15:0] phase_word,
    input logic        phase_vld,
    input logic [13:0] amp_word,
    input logic        amp_vld,
    input logic        done
);
    logic any_vld;
    assign any_vld = freq_vld || phase_vld || amp_vld;

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!any_vld && !done && freq_word == '0 && phase_word == '0 && amp_word == '0));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !play_en |=> !any_vld);

    // R10
    idle_done_chk: assert property (@(posedge clk) disable iff (rst)
        !play_en |=> !done);

    // R5
    single_dest_chk: assert property (@(posedge clk) disable iff (rst)
        freq_vld |-> (!phase_vld && !amp_vld));

    // R8
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> !any_vld);
endmodule

bind wave_ram_player wrp_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .play_en    (play_en),
    .freq_word  (freq_word),
    .freq_vld   (freq_vld),
    .phase_word (phase_word),
    .phase_vld  (phase_vld),
    .amp_word   (amp_word),
    .amp_vld    (amp_vld),
    .done       (done)
);

// File: tb/wave_ram_player_tb.sv
`timescale 1ns/1ps
module wave_ram_player_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        play_en = 1'b0, update = 1'b0;
    logic [2:0]  profile_sel = '0;
    logic        mem_we = 1'b0;
    logic [9:0]  mem_addr = '0;
    logic [31:0] mem_wdata = '0;
    logic        prof_we = 1'b0;
    logic [2:0]  prof_idx = '0;
    logic [9:0]  prof_first = '0, prof_last = '0;
    logic [15:0] prof_rate = '0;
    logic [1:0]  prof_dest = '0;
    logic [31:0] freq_word;
    logic [15:0] phase_word;
    logic [13:0] amp_word;
    logic        freq_vld, phase_vld, amp_vld, done;

    typedef struct { int at; int dst; logic [31:0] word; logic last; } exp_t;
    typedef struct { int first; int last; int rate; int dst; } bprof_t;

    exp_t        exp_q [$];
    exp_t        e;
    bprof_t      tp [8];
    logic [31:0] model [1024];
    int cyc = 0, checks = 0, fails = 0, vld_count = 0, snap = 0;
    localparam int NOLIM = 1000000;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wave_ram_player u_dut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", req, got, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    function automatic logic [31:0] pattern(input int i);
        return (32'(i) * 32'h9E3779B1) ^ 32'h13572468;
    endfunction

    task automatic push_run(input int p, input int n, input int lim);
        int a = tp[p].first;
        int k = 0;
        while (1) begin
            exp_t x;
            x.at = n + 3 + k * (tp[p].rate + 1);
            if (x.at > lim) break;
            x.dst = tp[p].dst; x.word = model[a]; x.last = (a == tp[p].last);
            exp_q.push_back(x);
            if (a == tp[p].last) break;
            a = (a + 1) % 1024;
            k++;
        end
    endtask

    task automatic wr_mem(input int a, input logic [31:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = 10'(a); mem_wdata = d;
        if (!play_en) model[a] = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic wr_prof(input int i, input int f, input int l, input int r, input int d);
        @(negedge clk);
        prof_we = 1'b1; prof_idx = 3'(i); prof_first = 10'(f); prof_last = 10'(l);
        prof_rate = 16'(r); prof_dest = 2'(d);
        tp[i] = '{f, l, r, d};
        @(negedge clk);
        prof_we = 1'b0;
    endtask

    task automatic strobe(input int lim_rel);
        int n;
        @(negedge clk);
        n = cyc; update = 1'b1;
        if (play_en) push_run(int'(profile_sel), n, n + lim_rel);
        @(negedge clk);
        update = 1'b0;
    endtask

    task automatic change_prof(input int p, input int lim_rel);
        int n;
        @(negedge clk);
        n = cyc; profile_sel = 3'(p);
        if (play_en) push_run(p, n, n + lim_rel);
    endtask

    always @(negedge clk) begin
        if (!rst && (freq_vld || phase_vld || amp_vld)) begin
            vld_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected sample", {61'b0, freq_vld, phase_vld, amp_vld}, 0);
            end else begin
                e = exp_q.pop_front();
                check(cyc == e.at, "R3 sample timing", 64'(cyc), 64'(e.at));
                case (e.dst)
                    0: check(freq_vld && !phase_vld && !amp_vld && freq_word == e.word,
                             "R5/R7 frequency route", freq_word, e.word);
                    1: check(phase_vld && !freq_vld && !amp_vld && phase_word == e.word[31:16],
                             "R5/R7 phase route", phase_word, e.word[31:16]);
                    2: check(amp_vld && !freq_vld && !phase_vld && amp_word == e.word[31:18],
                             "R5/R7 amplitude route", amp_word, e.word[31:18]);
                    default: check(phase_vld && amp_vld && !freq_vld &&
                                   phase_word == e.word[31:16] && amp_word == e.word[15:2],
                                   "R6 polar split", {phase_word, amp_word}, {e.word[31:16], e.word[15:2]});
                endcase
                check(done == e.last, "R8 done with last sample", done, e.last);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog expired got=%0d exp=%0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(!freq_vld && !phase_vld && !amp_vld && !done, "R11 flags after reset",
              {freq_vld, phase_vld, amp_vld, done}, 0);
        check(freq_word == 0 && phase_word == 0 && amp_word == 0, "R11 words after reset",
              {freq_word, phase_word[15:0]}, 0);

        for (int i = 0; i < 1024; i++) wr_mem(i, pattern(i));
        wr_prof(0, 4, 7, 0, 0);
        wr_prof(1, 10, 12, 3, 1);
        wr_prof(2, 20, 21, 1, 2);
        wr_prof(3, 30, 33, 2, 3);
        wr_prof(4, 1022, 1, 0, 0);
        wr_prof(5, 100, 140, 4, 0);
        wr_prof(6, 50, 50, 0, 3);

        // R2 strobe while disabled
        strobe(NOLIM);
        repeat (20) @(negedge clk);
        check(vld_count == 0, "R2 strobe while disabled", vld_count, 0);
        // R2 enable alone
        play_en = 1'b1;
        repeat (10) @(negedge clk);
        check(vld_count == 0, "R2 enable without strobe", vld_count, 0);

        // R3 R7 rate 0 run
        strobe(NOLIM);
        repeat (12) @(negedge clk);
        check(done == 1'b1, "R8 done after stretch", done, 1);
        check(exp_q.size() == 0, "R7 stretch complete", exp_q.size(), 0);
        snap = vld_count;
        repeat (10) @(negedge clk);
        check(vld_count == snap && done, "R8 hold after end", vld_count, snap);

        // R1 write while enabled is ignored; R9 restart clears done
        wr_mem(5, 32'hDEADBEEF);
        strobe(NOLIM);
        check(done == 1'b0, "R9 done cleared on restart", done, 0);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R1 locked write replay", exp_q.size(), 0);

        // R4 profile changes start each slot
        change_prof(1, NOLIM); repeat (20) @(negedge clk);
        change_prof(2, NOLIM); repeat (15) @(negedge clk);
        change_prof(3, NOLIM); repeat (20) @(negedge clk);
        change_prof(4, NOLIM); repeat (15) @(negedge clk);
        change_prof(6, NOLIM); repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R4 profile change runs", exp_q.size(), 0);
        check(done == 1'b1, "R8 single sample stretch done", done, 1);

        // R9 restart on a fetch edge discards the in-flight sample
        change_prof(5, 12);
        repeat (11) @(negedge clk);
        strobe(NOLIM);
        repeat (220) @(negedge clk);
        check(exp_q.size() == 0, "R9 restart from first address", exp_q.size(), 0);

        // R10 disable mid-run
        strobe(20);
        repeat (18) @(negedge clk);
        @(negedge clk);
        play_en = 1'b0;
        snap = vld_count;
        repeat (20) @(negedge clk);
        check(vld_count == snap, "R10 no samples while disabled", vld_count, snap);
        check(done == 1'b0, "R10 done low while disabled", done, 0);

        // R1 write while disabled is accepted
        change_prof(0, NOLIM);
        wr_mem(5, 32'hCAFEF00D);
        @(negedge clk);
        play_en = 1'b1;
        strobe(NOLIM);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R1 unlocked write replay", exp_q.size(), 0);
        check(model[5] == 32'hCAFEF00D, "R1 model updated", model[5], 32'hCAFEF00D);

        summary();
        $finish;
    end
endmodule